// File: doc/BRIEF.md
# Timer Channel Input Capture Front-End

This block conditions a single external timer channel pin and converts its transitions into capture strobes. The raw pin passes through a two-stage synchronizer and then a digital glitch filter. The filter accepts a new level only after a run of consecutive equal samples. Its sampling rate and run length both come from a 4-bit filter code. The filtered level feeds an edge detector that picks rising edges, falling edges or both.

Each qualified edge is exported at once as a one-cycle trigger pulse for other timer logic. The same edge also counts toward an event prescaler. The prescaler lets only every 1st, 2nd, 4th or 8th edge through to capture.

When an event survives the prescaler and the channel is set up as an input on its own pin with capture enabled, the block copies the free-running counter value into its capture register. It also raises a sticky capture flag. If a capture arrives while the flag is still set, a sticky overcapture flag is raised as well. Both flags are cleared by a single-cycle clear input.

Top module: `tim_capture_chan`

## Requirements
- R1: After reset, `cap_val_o` is 0, `cap_flag_o` and `ovr_flag_o` are 0, and `trig_o` is 0.
- R2: With filter code 0, a qualified pin edge driven between clock edges raises `trig_o` for one cycle, 3 clock edges later. On the next edge it loads `cap_val_o` with the `cnt_i` value present at that edge and sets `cap_flag_o`. Later changes of `cnt_i` leave `cap_val_o` unchanged.
- R3: Edge selection uses `edge_fall_i` and `edge_both_i` as follows. With `edge_fall_i`=0, rising edges are qualified, whatever the value of `edge_both_i`. With `edge_fall_i`=1 and `edge_both_i`=0, falling edges are qualified. With both bits at 1, both edges are qualified. An unselected edge produces neither a trigger nor a capture.
- R4: `trig_o` pulses on every qualified edge, whatever the values of `cap_en_i`, `chan_mode_i` and the prescaler.
- R5: Prescaler code `psc_code_i` 00/01/10/11 captures on every 1st/2nd/4th/8th qualified edge.
- R6: While capture is inactive, the prescaler event count is held at zero. After capture is re-enabled, a full group of edges is needed again.
- R7: Capture happens only when `cap_en_i`=1 and `chan_mode_i`=2'b01 (input mapped to its own pin). Codes 00 (output), 10 and 11 never capture. A capture-inactive edge leaves `cap_val_o` and `cap_flag_o` unchanged.
- R8: A capture that occurs while `cap_flag_o` is already 1 sets `ovr_flag_o`.
- R9: A one-cycle `flag_clr_i` pulse with no capture in the same cycle clears both flags.
- R10: Filter codes 1, 2 and 3 sample once every clock and need 2, 4 and 8 consecutive differing samples. Code 3 therefore rejects a 5-cycle pulse and passes a 15-cycle pulse.
- R11: Filter codes 4 to 15 sample once every 2, 4, 8, 16 or 32 `samp_en_i` ticks and need 5, 6 or 8 samples. Code 4 uses 2 ticks and 6 samples. With `samp_en_i` high every clock it rejects an 8-cycle pulse and passes a 30-cycle pulse. With `samp_en_i` held low, the filtered level never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_en_i | input | 1 | Base tick for filter sampling at codes 4 and above |
| pin_i | input | 1 | Raw, asynchronous channel pin |
| cnt_i | input | CNT_W | Free-running counter value |
| filt_code_i | input | 4 | Filter rate and sample-count code |
| edge_fall_i | input | 1 | Edge polarity select |
| edge_both_i | input | 1 | Together with edge_fall_i, selects both edges |
| psc_code_i | input | 2 | Event prescaler code |
| chan_mode_i | input | 2 | Channel direction/mapping select |
| cap_en_i | input | 1 | Capture enable |
| flag_clr_i | input | 1 | Clears capture and overcapture flags |
| trig_o | output | 1 | Qualified edge pulse for trigger use |
| cap_val_o | output | CNT_W | Captured counter value |
| cap_flag_o | output | 1 | Sticky capture flag |
| ovr_flag_o | output | 1 | Sticky overcapture flag |

## Verification
Two situations are hardest to reach from the ports. The first is the prescaler's hidden event count being cleared by a disable. The bench sets a divide-by-2 prescaler and lands one edge. It then disables capture and lands a second edge, which must still appear on `trig_o`. After re-enabling, it shows that one more edge is not enough and a second is needed. The second situation is the tick-based filter starved of `samp_en_i`. There the bench holds a long pulse that would pass at full rate and confirms that no trigger appears.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef struct packed {
        logic       tick_based;
        logic [2:0] div_log2;
        logic [3:0] need;
    } filt_cfg_t;

    typedef enum logic [1:0] {
        CH_OUTPUT  = 2'b00,
        CH_IN_OWN  = 2'b01,
        CH_IN_ALT  = 2'b10,
        CH_IN_TRG  = 2'b11
    } ch_mode_e;

    function automatic filt_cfg_t decode_filt(input logic [3:0] code);
        filt_cfg_t c;
        c = '{tick_based: 1'b0, div_log2: 3'd0, need: 4'd1};
        unique case (code)
            4'd0:  c = '{1'b0, 3'd0, 4'd1};
            4'd1:  c = '{1'b0, 3'd0, 4'd2};
            4'd2:  c = '{1'b0, 3'd0, 4'd4};
            4'd3:  c = '{1'b0, 3'd0, 4'd8};
            4'd4:  c = '{1'b1, 3'd1, 4'd6};
            4'd5:  c = '{1'b1, 3'd1, 4'd8};
            4'd6:  c = '{1'b1, 3'd2, 4'd6};
            4'd7:  c = '{1'b1, 3'd2, 4'd8};
            4'd8:  c = '{1'b1, 3'd3, 4'd6};
            4'd9:  c = '{1'b1, 3'd3, 4'd8};
            4'd10: c = '{1'b1, 3'd4, 4'd5};
            4'd11: c = '{1'b1, 3'd4, 4'd6};
            4'd12: c = '{1'b1, 3'd4, 4'd8};
            4'd13: c = '{1'b1, 3'd5, 4'd5};
            4'd14: c = '{1'b1, 3'd5, 4'd6};
            default: c = '{1'b1, 3'd5, 4'd8};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cap_filter.sv
module cap_filter #(
    parameter int SYNC_N = 2,
    parameter int DIV_W  = 5,
    parameter int RUN_W  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       samp_en_i,
    input  logic       pin_i,
    input  logic [3:0] code_i,
    output logic       lvl_o
);
    import cap_pkg::*;

    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic [DIV_W-1:0]  div;
        logic [RUN_W-1:0]  run;
        logic              lvl;
    } filt_state_t;

    filt_state_t state_d, state_q;
    filt_cfg_t   cfg;
    logic        stb;
    logic        smp;
    logic [DIV_W-1:0] div_lim;
    logic [RUN_W-1:0] run_inc;

    always_comb begin
        cfg     = decode_filt(code_i);
        state_d = state_q;
        stb     = 1'b0;
        smp     = state_q.sync[SYNC_N-1];
        div_lim = (DIV_W'(1) << cfg.div_log2) - DIV_W'(1);
        run_inc = state_q.run + RUN_W'(1);

        state_d.sync = {state_q.sync[SYNC_N-2:0], pin_i};

        if (!cfg.tick_based) begin
            stb         = 1'b1;
            state_d.div = '0;
        end else if (samp_en_i) begin
            if (state_q.div >= div_lim) begin
                stb         = 1'b1;
                state_d.div = '0;
            end else begin
                state_d.div = state_q.div + DIV_W'(1);
            end
        end

        if (stb) begin
            if (smp != state_q.lvl) begin
                if (run_inc >= RUN_W'(cfg.need)) begin
                    state_d.lvl = smp;
                    state_d.run = '0;
                end else begin
                    state_d.run = run_inc;
                end
            end else begin
                state_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign lvl_o = state_q.lvl;

    // R11
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(state_q.lvl));

    // R10
    lvl_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.lvl != $past(state_q.lvl)) |-> (state_q.lvl == $past(state_q.sync[SYNC_N-1])));

endmodule

// File: rtl/cap_edge.sv
module cap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic fall_i,
    input  logic both_i,
    output logic evt_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t state_d, state_q;
    logic rise, fall;

    always_comb begin
        state_d      = state_q;
        state_d.prev = lvl_i;
        rise         = lvl_i & ~state_q.prev;
        fall         = ~lvl_i & state_q.prev;
        if (fall_i && both_i) evt_o = rise | fall;
        else if (fall_i)      evt_o = fall;
        else                  evt_o = rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R3
    edge_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> ($past(lvl_i) != $past(state_q.prev)));

endmodule

// File: rtl/cap_prescale.sv
module cap_prescale #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              evt_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              fire_o
);
    localparam int EC_W = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [EC_W-1:0] cnt;
    } psc_state_t;

    psc_state_t state_d, state_q;
    logic [EC_W-1:0] lim;

    always_comb begin
        state_d = state_q;
        fire_o  = 1'b0;
        lim     = (EC_W'(1) << code_i) - EC_W'(1);
        if (!en_i) begin
            state_d.cnt = '0;
        end else if (evt_i) begin
            if (state_q.cnt >= lim) begin
                fire_o      = 1'b1;
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt + EC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R5
    fire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> (en_i && evt_i));

    // R6
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && $past(!en_i)) |-> !fire_o);

endmodule

// File: rtl/tim_capture_chan.sv
module tim_capture_chan #(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en_i,
    input  logic             pin_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [3:0]       filt_code_i,
    input  logic             edge_fall_i,
    input  logic             edge_both_i,
    input  logic [1:0]       psc_code_i,
    input  logic [1:0]       chan_mode_i,
    input  logic             cap_en_i,
    input  logic             flag_clr_i,
    output logic             trig_o,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             cap_flag_o,
    output logic             ovr_flag_o
);
    import cap_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             flag;
        logic             ovr;
    } cap_state_t;

    cap_state_t state_d, state_q;
    logic lvl, evt, fire, cap_active;

    cap_filter #(.SYNC_N(SYNC_N), .DIV_W(5), .RUN_W(4)) u_filt (
        .clk(clk), .rst_n(rst_n), .samp_en_i(samp_en_i), .pin_i(pin_i),
        .code_i(filt_code_i), .lvl_o(lvl)
    );

    cap_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .fall_i(edge_fall_i),
        .both_i(edge_both_i), .evt_o(evt)
    );

    assign cap_active = cap_en_i && (chan_mode_i == CH_IN_OWN);

    cap_prescale #(.CODE_W(2)) u_psc (
        .clk(clk), .rst_n(rst_n), .en_i(cap_active), .evt_i(evt),
        .code_i(psc_code_i), .fire_o(fire)
    );

    always_comb begin
        state_d      = state_q;
        state_d.flag = state_q.flag & ~flag_clr_i;
        state_d.ovr  = state_q.ovr  & ~flag_clr_i;
        if (fire) begin
            state_d.val  = cnt_i;
            state_d.flag = 1'b1;
            if (state_q.flag && !flag_clr_i) state_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign trig_o     = evt;
    assign cap_val_o  = state_q.val;
    assign cap_flag_o = state_q.flag;
    assign ovr_flag_o = state_q.ovr;

    // R2
    cap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cap_flag_o);

    // R7
    inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_active |=> $stable(cap_val_o));

    // R8
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag_o) |-> $past(cap_flag_o));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !fire) |=> (!cap_flag_o && !ovr_flag_o));

endmodule

// File: tb/tim_capture_chan_test.sv
`timescale 1ns/1ps
module tim_capture_chan_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             samp_en_i = 1'b1;
    logic             pin_i = 1'b0;
    logic [CNT_W-1:0] cnt_i = '0;
    logic [3:0]       filt_code_i = 4'd0;
    logic             edge_fall_i = 1'b0;
    logic             edge_both_i = 1'b0;
    logic [1:0]       psc_code_i = 2'b00;
    logic [1:0]       chan_mode_i = 2'b01;
    logic             cap_en_i = 1'b1;
    logic             flag_clr_i = 1'b0;
    logic             trig_o;
    logic [CNT_W-1:0] cap_val_o;
    logic             cap_flag_o;
    logic             ovr_flag_o;

    int n_run = 0;
    int n_fail = 0;
    int trig_cnt = 0;

    always #2.5 clk = ~clk;

    tim_capture_chan #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .samp_en_i(samp_en_i), .pin_i(pin_i),
        .cnt_i(cnt_i), .filt_code_i(filt_code_i), .edge_fall_i(edge_fall_i),
        .edge_both_i(edge_both_i), .psc_code_i(psc_code_i),
        .chan_mode_i(chan_mode_i), .cap_en_i(cap_en_i), .flag_clr_i(flag_clr_i),
        .trig_o(trig_o), .cap_val_o(cap_val_o), .cap_flag_o(cap_flag_o),
        .ovr_flag_o(ovr_flag_o)
    );

    always @(negedge clk) if (rst_n && trig_o) trig_cnt++;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags();
        flag_clr_i = 1'b1; clks(1); flag_clr_i = 1'b0; clks(1);
    endtask

    task automatic pulse(input int hi, input int lo);
        pin_i = 1'b1; clks(hi); pin_i = 1'b0; clks(lo);
    endtask

    task automatic t_reset();
        chk(cap_val_o == 0, "R1 cap_val", cap_val_o, 0);
        chk(!cap_flag_o && !ovr_flag_o, "R1 flags", {cap_flag_o, ovr_flag_o}, 0);
        chk(!trig_o, "R1 trig", trig_o, 0);
    endtask

    task automatic t_rise();
        int t0 = trig_cnt;
        cnt_i = 16'h1234; pin_i = 1'b1; clks(6);
        chk(cap_flag_o, "R2 flag", cap_flag_o, 1);
        chk(cap_val_o == 16'h1234, "R2 value", cap_val_o, 16'h1234);
        chk(trig_cnt - t0 == 1, "R2 trig count", trig_cnt - t0, 1);
        cnt_i = 16'h4321; clks(3);
        chk(cap_val_o == 16'h1234, "R2 value held", cap_val_o, 16'h1234);
        clear_flags();
        chk(!cap_flag_o && !ovr_flag_o, "R9 clear", {cap_flag_o, ovr_flag_o}, 0);
    endtask

    task automatic t_polarity();
        cnt_i = 16'hAAAA; pin_i = 1'b0; clks(6);
        chk(!cap_flag_o, "R3 fall ignored when rising", cap_flag_o, 0);
        edge_fall_i = 1'b1;
        pin_i = 1'b1; clks(6);
        chk(!cap_flag_o, "R3 rise ignored when falling", cap_flag_o, 0);
        cnt_i = 16'h0BAD; pin_i = 1'b0; clks(6);
        chk(cap_flag_o && cap_val_o == 16'h0BAD, "R3 falling capture", cap_val_o, 16'h0BAD);
        clear_flags();
        edge_both_i = 1'b1;
        begin
            int t0 = trig_cnt;
            pulse(6, 6);
            chk(trig_cnt - t0 == 2, "R3 both edges", trig_cnt - t0, 2);
        end
        chk(ovr_flag_o, "R8 overcapture", ovr_flag_o, 1);
        clear_flags();
        chk(!ovr_flag_o, "R9 ovr clear", ovr_flag_o, 0);
        edge_fall_i = 1'b0;
        begin
            int t0 = trig_cnt;
            pulse(6, 6);
            chk(trig_cnt - t0 == 1, "R3 both bit alone is rising", trig_cnt - t0, 1);
        end
        edge_both_i = 1'b0;
        clear_flags();
    endtask

    task automatic t_prescale();
        psc_code_i = 2'b10;
        pulse(6, 6); pulse(6, 6); pulse(6, 6);
        chk(!cap_flag_o, "R5 /4 no capture after 3", cap_flag_o, 0);
        cnt_i = 16'h0444; pulse(6, 6);
        chk(cap_flag_o && cap_val_o == 16'h0444, "R5 /4 capture on 4th", cap_val_o, 16'h0444);
        clear_flags();
        psc_code_i = 2'b01;
        pulse(6, 6);
        cap_en_i = 1'b0;
        begin
            int t0 = trig_cnt;
            cnt_i = 16'h0555; pulse(6, 6);
            chk(trig_cnt - t0 == 1, "R4 trig while disabled", trig_cnt - t0, 1);
        end
        chk(!cap_flag_o && cap_val_o == 16'h0444, "R7 no capture while disabled", cap_val_o, 16'h0444);
        cap_en_i = 1'b1;
        pulse(6, 6);
        chk(!cap_flag_o, "R6 count restarted", cap_flag_o, 0);
        cnt_i = 16'h0666; pulse(6, 6);
        chk(cap_flag_o && cap_val_o == 16'h0666, "R6 capture after full group", cap_val_o, 16'h0666);
        psc_code_i = 2'b00;
        clear_flags();
    endtask

    task automatic t_mode();
        for (int m = 0; m < 4; m++) begin
            if (m != 1) begin
                int t0 = trig_cnt;
                chan_mode_i = m[1:0];
                cnt_i = 16'h0700 + 16'(m);
                pulse(6, 6);
                chk(!cap_flag_o && cap_val_o == 16'h0666, "R7 mode blocks capture", cap_val_o, 16'h0666);
                chk(trig_cnt - t0 == 1, "R4 trig in any mode", trig_cnt - t0, 1);
            end
        end
        chan_mode_i = 2'b01;
    endtask

    task automatic t_filt_clk();
        int t0;
        filt_code_i = 4'd3;
        t0 = trig_cnt;
        pulse(5, 20);
        chk(trig_cnt == t0, "R10 short pulse rejected", trig_cnt - t0, 0);
        cnt_i = 16'h0888;
        pulse(15, 20);
        chk(trig_cnt - t0 == 1, "R10 long pulse passes", trig_cnt - t0, 1);
        chk(cap_flag_o && cap_val_o == 16'h0888, "R10 capture", cap_val_o, 16'h0888);
        clear_flags();
    endtask

    task automatic t_filt_tick();
        int t0;
        filt_code_i = 4'd4;
        samp_en_i = 1'b1;
        t0 = trig_cnt;
        pulse(8, 30);
        chk(trig_cnt == t0, "R11 short pulse rejected", trig_cnt - t0, 0);
        pulse(30, 30);
        chk(trig_cnt - t0 == 1, "R11 long pulse passes", trig_cnt - t0, 1);
        samp_en_i = 1'b0;
        t0 = trig_cnt;
        pulse(40, 30);
        chk(trig_cnt == t0, "R11 no tick no change", trig_cnt - t0, 0);
        samp_en_i = 1'b1;
        filt_code_i = 4'd0;
        clks(10);
        clear_flags();
    endtask

    initial begin
        #20000000;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        clks(3);
        rst_n = 1'b1;
        clks(2);
        t_reset();
        t_rise();
        t_polarity();
        t_prescale();
        t_mode();
        t_filt_clk();
        t_filt_tick();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule